// File: doc/BRIEF.md
# Set-Associative Write-Back Byte Cache

This block is a byte-addressed cache placed between a processor-side request port and a memory port that moves whole blocks. The processor port carries one read or write of a single byte at a time with a valid/ready handshake. The block answers with a one-cycle response that returns the byte and says whether the access hit. The memory port issues block-wide read and write requests and waits for a done pulse.

The address is split into a tag, a set index and a byte offset within the block. All ways of the indexed set are compared at once. A miss picks a line: an empty way if the set has one, otherwise the least recently used way. If that line holds modified data it is first copied back to memory. The block is then fetched, and the access is replayed on the fresh line. Writes that hit only modify the stored line and mark it dirty. Writes that miss fetch the block first. Setting the way count to one gives a direct-mapped cache.

Top module: `wb_cache`

## Requirements
- R1: The address is split with the tag in the high bits, the set index in the middle and the byte offset in the low log2(BLK) bits. Every memory request carries a block-aligned address whose offset bits are zero. Addresses that differ only in set index never evict each other.
- R2: After reset every line is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first access to any address is reported as a miss.
- R3: An access hits when some way of the indexed set is valid and holds the address tag. A read returns the byte selected by the offset.
- R4: A miss fetches the whole block, so a later access to another byte of the same block hits.
- R5: On a miss, an invalid way of the set is filled before any valid line is evicted.
- R6: When every way of the set is valid, the victim is the way whose last hit or fill is oldest.
- R7: A write hit changes only the cached byte and marks the line dirty. It issues no memory write, and a later read of that byte returns the new value.
- R8: A dirty victim is written to memory with its full modified contents, using a block write (`mem_req_write`=1), before the block read for the new line. A clean victim causes no memory write.
- R9: A write miss fetches the block, then writes the byte into the line. It reports a miss, and later reads of that block hit with the merged data.
- R10: With 4-bit addresses, BLK=2, SETS=2 and WAYS=2, reads of bytes 0, 1, 7, 8, 0 give miss, hit, miss, miss, hit.
- R11: With 4-bit addresses, BLK=2, SETS=4 and WAYS=1, the same reads give miss, hit, miss, miss, miss.
- R12: `req_ready` is 1 only while the block is idle. No request is accepted until the response to the previous one has been given. `rsp_valid` lasts exactly one cycle. For a hit it is high in the second cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit | output | 1 | 1 when the access hit on first lookup |
| rsp_rdata | output | 8 | Byte read (write: stored byte) |
| mem_req_valid | output | 1 | Memory request active |
| mem_req_write | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_req_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 8*BLK | Block being written back |
| mem_done | input | 1 | Memory finished the current request |
| mem_rdata | input | 8*BLK | Fetched block, valid with mem_done |

## Verification
A hit answers with `rsp_valid` in the second cycle after the accepting edge. The bench stamps each request with its acceptance cycle and requires exactly that distance for every expected hit. A miss answers only after the optional write-back, the fill and one more lookup. For misses the bench places no fixed distance and instead checks, at every falling edge until the response arrives, that `req_ready` stays low. Memory writes are counted at the done pulse of each write-back, and the bench compares the count only after the response, so write-backs are judged once the whole miss sequence has finished.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_DONE
  } cache_st_e;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_v,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_v,
  input  logic [TAG_W-1:0]           tag_in,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_v[w] && (tags_v[w] == tag_in)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS = 2,
  parameter int WAYS = 2,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] lru_way
);
  // age 0 = most recent, WAYS-1 = oldest; ages in a set form a permutation
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[query_set][w] == WAY_W'(WAYS - 1))
        lru_way = WAY_W'(w);
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  valid_v,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim_way
);
  logic             have_free;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    have_free = 1'b0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_v[w]) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
    end
    victim_way = have_free ? free_way : lru_way;
  end
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SETS   = 2,
  parameter int WAYS   = 2,
  parameter int BLK    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [7:0]          req_wdata,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [7:0]          rsp_rdata,
  output logic                mem_req_valid,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [8*BLK-1:0]    mem_wdata,
  input  logic                mem_done,
  input  logic [8*BLK-1:0]    mem_rdata
);
  localparam int OFF_W  = $clog2(BLK);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINE_W = 8 * BLK;

  // address arithmetic kept in functions
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [ADDR_W-1:0] f_blk(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  cache_st_e         state;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [7:0]        q_wdata;
  logic              q_missed;
  logic [WAY_W-1:0]  victim_q;
  logic [7:0]        rdata_q;
  logic              hit_q;

  logic             valid_a [SETS][WAYS];
  logic             dirty_a [SETS][WAYS];
  logic [TAG_W-1:0] tag_a   [SETS][WAYS];
  logic [LINE_W-1:0] data_a [SETS][WAYS];

  logic [SET_W-1:0]            cur_set;
  logic [TAG_W-1:0]            cur_tag;
  logic [OFF_W-1:0]            cur_off;
  logic [WAYS-1:0]             set_valid;
  logic [WAYS-1:0][TAG_W-1:0]  set_tags;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way;
  logic [WAY_W-1:0]            lru_way;
  logic [WAY_W-1:0]            alloc_way;
  logic                        alloc_dirty;

  // named events for the checker
  logic ev_hit, ev_miss, ev_wb_done, ev_fill_done, evict_dirty;

  assign cur_set = f_set(q_addr);
  assign cur_tag = f_tag(q_addr);
  assign cur_off = f_off(q_addr);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_a[cur_set][w];
      set_tags[w]  = tag_a[cur_set][w];
    end
  end

  cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
    .valid_v (set_valid),
    .tags_v  (set_tags),
    .tag_in  (cur_tag),
    .hit     (hit),
    .hit_way (hit_way)
  );

  assign ev_hit       = (state == ST_LOOKUP) && hit;
  assign ev_miss      = (state == ST_LOOKUP) && !hit;
  assign ev_wb_done   = (state == ST_WBACK) && mem_done;
  assign ev_fill_done = (state == ST_FILL) && mem_done;

  cache_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (ev_hit || ev_fill_done),
    .touch_set (cur_set),
    .touch_way (ev_hit ? hit_way : victim_q),
    .query_set (cur_set),
    .lru_way   (lru_way)
  );

  cache_victim_sel #(.WAYS(WAYS)) i_victim (
    .valid_v    (set_valid),
    .lru_way    (lru_way),
    .victim_way (alloc_way)
  );

  assign alloc_dirty = valid_a[cur_set][alloc_way] && dirty_a[cur_set][alloc_way];
  assign evict_dirty = valid_a[cur_set][victim_q] && dirty_a[cur_set][victim_q];

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_hit       = hit_q;
  assign rsp_rdata     = rdata_q;
  assign mem_req_valid = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_req_write = (state == ST_WBACK);
  assign mem_req_addr  = (state == ST_WBACK) ? f_blk(tag_a[cur_set][victim_q], cur_set)
                                             : f_blk(cur_tag, cur_set);
  assign mem_wdata     = data_a[cur_set][victim_q];

  // control, valid and dirty state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_write  <= 1'b0;
      q_addr   <= '0;
      q_wdata  <= '0;
      q_missed <= 1'b0;
      victim_q <= '0;
      rdata_q  <= '0;
      hit_q    <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_a[s][w] <= 1'b0;
          dirty_a[s][w] <= 1'b0;
        end
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          q_write  <= req_write;
          q_addr   <= req_addr;
          q_wdata  <= req_wdata;
          q_missed <= 1'b0;
          state    <= ST_LOOKUP;
        end
        ST_LOOKUP: if (hit) begin
          hit_q <= !q_missed;
          if (q_write) begin
            dirty_a[cur_set][hit_way] <= 1'b1;
            rdata_q <= q_wdata;
          end else begin
            rdata_q <= data_a[cur_set][hit_way][int'(cur_off)*8 +: 8];
          end
          state <= ST_DONE;
        end else begin
          victim_q <= alloc_way;
          q_missed <= 1'b1;
          state    <= alloc_dirty ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (mem_done) state <= ST_FILL;
        ST_FILL: if (mem_done) begin
          valid_a[cur_set][victim_q] <= 1'b1;
          dirty_a[cur_set][victim_q] <= 1'b0;
          state <= ST_LOOKUP;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // tag and data storage
  always_ff @(posedge clk) begin
    if (ev_fill_done) begin
      tag_a[cur_set][victim_q]  <= cur_tag;
      data_a[cur_set][victim_q] <= mem_rdata;
    end else if (ev_hit && q_write) begin
      data_a[cur_set][hit_way][int'(cur_off)*8 +: 8] <= q_wdata;
    end
  end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              ev_hit,
  input logic              ev_miss,
  input logic              ev_wb_done,
  input logic              ev_fill_done,
  input logic              evict_dirty
);
  // R12: while ready, nothing else is in flight
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));

  // R12: response lasts one cycle and is followed by idle
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R1: memory requests are block aligned
  p_blk_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R8: a write-back only ever evicts a dirty line
  p_wb_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> evict_dirty);

  // R8: the block read follows a finished write-back
  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> (mem_req_valid && !mem_req_write));

  // R9: after a fill the replayed access hits
  p_fill_then_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> ev_hit);

  // R4: a miss never answers directly
  p_miss_no_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (!rsp_valid && mem_req_valid));
endmodule

bind wb_cache cache_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .ev_hit        (ev_hit),
  .ev_miss       (ev_miss),
  .ev_wb_done    (ev_wb_done),
  .ev_fill_done  (ev_fill_done),
  .evict_dirty   (evict_dirty)
);

// File: tb/test_wb_cache.sv
module cache_mem_model #(
  parameter int ADDR_W = 4,
  parameter int BLK    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [8*BLK-1:0]  wdata,
  output logic              done,
  output logic [8*BLK-1:0]  rdata,
  output int                wr_count
);
  logic [7:0] mem [2**ADDR_W];

  always_comb
    for (int i = 0; i < BLK; i++)
      rdata[i*8 +: 8] = mem[int'(req_addr) + i];

  always @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      wr_count <= 0;
      for (int i = 0; i < 2**ADDR_W; i++) mem[i] <= 8'(i * 13 + 5);
    end else begin
      done <= req_valid && !done;
      if (done && req_write) begin
        for (int i = 0; i < BLK; i++) mem[int'(req_addr) + i] <= wdata[i*8 +: 8];
        wr_count <= wr_count + 1;
      end
    end
  end
endmodule

module test_wb_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid [2];
  logic       req_ready [2];
  logic       req_write [2];
  logic [3:0] req_addr  [2];
  logic [7:0] req_wdata [2];
  logic       rsp_valid [2];
  logic       rsp_hit   [2];
  logic [7:0] rsp_rdata [2];
  logic       mem_req_valid [2];
  logic       mem_req_write [2];
  logic [3:0] mem_req_addr  [2];
  logic [15:0] mem_wdata    [2];
  logic       mem_done      [2];
  logic [15:0] mem_rdata    [2];
  int         wr_cnt        [2];

  wb_cache #(.ADDR_W(4), .SETS(2), .WAYS(2), .BLK(2)) i_wb_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_hit(rsp_hit[0]), .rsp_rdata(rsp_rdata[0]),
    .mem_req_valid(mem_req_valid[0]), .mem_req_write(mem_req_write[0]),
    .mem_req_addr(mem_req_addr[0]), .mem_wdata(mem_wdata[0]),
    .mem_done(mem_done[0]), .mem_rdata(mem_rdata[0]));

  wb_cache #(.ADDR_W(4), .SETS(4), .WAYS(1), .BLK(2)) i_wb_cache_dm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_hit(rsp_hit[1]), .rsp_rdata(rsp_rdata[1]),
    .mem_req_valid(mem_req_valid[1]), .mem_req_write(mem_req_write[1]),
    .mem_req_addr(mem_req_addr[1]), .mem_wdata(mem_wdata[1]),
    .mem_done(mem_done[1]), .mem_rdata(mem_rdata[1]));

  cache_mem_model #(.ADDR_W(4), .BLK(2)) i_mem0 (
    .clk(clk), .rst_n(rst_n), .req_valid(mem_req_valid[0]), .req_write(mem_req_write[0]),
    .req_addr(mem_req_addr[0]), .wdata(mem_wdata[0]), .done(mem_done[0]),
    .rdata(mem_rdata[0]), .wr_count(wr_cnt[0]));

  cache_mem_model #(.ADDR_W(4), .BLK(2)) i_mem1 (
    .clk(clk), .rst_n(rst_n), .req_valid(mem_req_valid[1]), .req_write(mem_req_write[1]),
    .req_addr(mem_req_addr[1]), .wdata(mem_wdata[1]), .done(mem_done[1]),
    .rdata(mem_rdata[1]), .wr_count(wr_cnt[1]));

  typedef struct {
    bit         wr;
    bit         hit;
    logic [7:0] data;
    int         acc;
    string      req;
  } exp_t;

  exp_t       sb [2][$];
  logic [7:0] shadow [2][16];
  int         cyc = 0;
  int         n_tests = 0;
  int         n_fail = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as responses appear
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (mem_req_valid[k] && mem_done[k])
          chk(mem_req_addr[k][0] == 1'b0, "R1", "memory address offset bit", int'(mem_req_addr[k][0]), 0);
        if (rsp_valid[k]) begin
          if (sb[k].size() == 0) begin
            chk(1'b0, "R12", "response without request", 1, 0);
          end else begin
            exp_t e;
            e = sb[k].pop_front();
            chk(rsp_hit[k] == e.hit, e.req, "hit flag", int'(rsp_hit[k]), int'(e.hit));
            if (!e.wr)
              chk(rsp_rdata[k] == e.data, e.req, "read data", int'(rsp_rdata[k]), int'(e.data));
            if (e.hit)
              chk((cyc - e.acc) == 1, "R12", "hit latency (cycles after accept)", cyc - e.acc + 1, 2);
          end
        end
      end
    end
  end

  // driver: issues one access and waits for its response
  task automatic access(input int k, input bit wr, input logic [3:0] a, input logic [7:0] wd,
                        input bit exp_hit, input string req);
    exp_t e;
    bit   busy_bad;
    @(negedge clk);
    while (!req_ready[k]) @(negedge clk);
    req_valid[k] = 1'b1;
    req_write[k] = wr;
    req_addr[k]  = a;
    req_wdata[k] = wd;
    if (wr) shadow[k][a] = wd;
    e.wr   = wr;
    e.hit  = exp_hit;
    e.data = shadow[k][a];
    e.req  = req;
    @(posedge clk);
    #1;
    e.acc = cyc;
    sb[k].push_back(e);
    req_valid[k] = 1'b0;
    busy_bad = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (sb[k].size() == 0) break;
      if (req_ready[k]) busy_bad = 1'b1;
    end
    chk(!busy_bad, "R12", "ready stayed low while busy", int'(busy_bad), 0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 1'b0;
      req_write[k] = 1'b0;
      req_addr[k]  = '0;
      req_wdata[k] = '0;
      for (int i = 0; i < 16; i++) shadow[k][i] = 8'(i * 13 + 5);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(req_ready[k] == 1'b1, "R2", "ready after reset", int'(req_ready[k]), 1);
      chk(rsp_valid[k] == 1'b0, "R2", "rsp_valid after reset", int'(rsp_valid[k]), 0);
      chk(mem_req_valid[k] == 1'b0, "R2", "mem request after reset", int'(mem_req_valid[k]), 0);
    end

    // R10: two-way trace; R2 first access misses; R4 neighbour byte hits; R5 free way used
    access(0, 0, 4'd0, 8'h00, 1'b0, "R10");
    access(0, 0, 4'd1, 8'h00, 1'b1, "R4");
    access(0, 0, 4'd7, 8'h00, 1'b0, "R10");
    access(0, 0, 4'd8, 8'h00, 1'b0, "R5");
    access(0, 0, 4'd0, 8'h00, 1'b1, "R10");
    // R7: write hit stays in cache
    access(0, 1, 4'd8, 8'hA5, 1'b1, "R7");
    chk(wr_cnt[0] == 0, "R7", "memory writes after write hit", wr_cnt[0], 0);
    access(0, 0, 4'd8, 8'h00, 1'b1, "R7");
    // R6: LRU eviction; R8 dirty victim written back
    access(0, 0, 4'd0, 8'h00, 1'b1, "R3");
    access(0, 0, 4'd4, 8'h00, 1'b0, "R6");
    chk(wr_cnt[0] == 1, "R8", "memory writes after dirty eviction", wr_cnt[0], 1);
    chk(i_mem0.mem[8] == 8'hA5, "R8", "written-back byte", int'(i_mem0.mem[8]), 'hA5);
    access(0, 0, 4'd0, 8'h00, 1'b1, "R6");
    access(0, 0, 4'd8, 8'h00, 1'b0, "R8");
    chk(wr_cnt[0] == 1, "R8", "memory writes after clean eviction", wr_cnt[0], 1);
    // R9: write miss allocates
    access(0, 1, 4'd13, 8'h3C, 1'b0, "R9");
    access(0, 0, 4'd12, 8'h00, 1'b1, "R9");
    access(0, 0, 4'd13, 8'h00, 1'b1, "R9");
    access(0, 0, 4'd0, 8'h00, 1'b0, "R6");
    chk(wr_cnt[0] == 1, "R8", "memory writes, clean LRU victim", wr_cnt[0], 1);
    access(0, 0, 4'd4, 8'h00, 1'b0, "R8");
    chk(wr_cnt[0] == 2, "R8", "memory writes, allocated dirty victim", wr_cnt[0], 2);
    chk(i_mem0.mem[13] == 8'h3C, "R9", "merged byte in memory", int'(i_mem0.mem[13]), 'h3C);
    access(0, 0, 4'd13, 8'h00, 1'b0, "R9");

    // R11: direct-mapped trace
    access(1, 0, 4'd0, 8'h00, 1'b0, "R11");
    access(1, 0, 4'd1, 8'h00, 1'b1, "R11");
    access(1, 0, 4'd7, 8'h00, 1'b0, "R11");
    access(1, 0, 4'd8, 8'h00, 1'b0, "R11");
    access(1, 0, 4'd0, 8'h00, 1'b0, "R11");
    // R1: different set index, no conflict
    access(1, 0, 4'd2, 8'h00, 1'b0, "R1");
    access(1, 0, 4'd0, 8'h00, 1'b1, "R1");
    access(1, 0, 4'd3, 8'h00, 1'b1, "R3");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R12 watchdog expired: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule